// File: doc/BRIEF.md
# Timer Master Trigger Output Generator

This block is an up-counting timer that produces a one-bit synchronization trigger for slave timers. A prescaler divides the clock by a programmable amount. A counter steps on each prescaled tick and wraps to zero after it reaches a programmable auto-reload value. A three-bit master mode field selects which internal event the trigger output carries: a counter restart, the counter enable, the update event, or a channel 1 compare match. The timer also raises a one-cycle update DMA request strobe on every update event while that request is enabled.

Software programs the timer over a simple word-addressed register bus, with writes qualified by `bus_wr` and reads returned combinationally on `bus_rdata` for the address on `bus_addr`. Two inputs come from the surrounding slave logic. `slv_rst` restarts the counter. `gate_in` keeps the counter enabled while it is high.

The counter sequencing is a two-state machine held in a state register. ST_HALT moves to ST_COUNT when the counter enable (software enable OR `gate_in`) is true. ST_COUNT moves back to ST_HALT when that enable drops. Each state holds while the enable keeps its value. The prescaler and counter advance only in ST_COUNT.

Top module: `tmr_trig_master`

Register map (byte addresses; reserved bits read 0, writes to a read-only or unmapped address are ignored):

| Addr | Contents |
|------|----------|
| 0x00 | bit 0: software counter enable |
| 0x04 | bits 2:0: master mode select |
| 0x08 | bit 0 written 1: update-generate (self-clearing, reads 0) |
| 0x0C | bit 8: update DMA request enable |
| 0x10 | bit 0: channel 1 match flag (writing 0 clears it, writing 1 has no effect) |
| 0x14 | current counter value (read only) |
| 0x18 | prescaler divide value minus one |
| 0x1C | auto-reload value |
| 0x20 | channel 1 compare value |

## Requirements
- R1: After reset, `trig_out` and `upd_dma_req` are 0, and every register reads 0, including the mode select (000).
- R2: The mode select occupies bits 2:0 at 0x04. All other register bits not listed in the map read as 0, whatever was written to them.
- R3: In ST_COUNT the counter steps once every (prescaler+1) cycles. A step taken when the count equals the auto-reload value loads 0 and is an update event. The count reads back at 0x14.
- R4: With select 000, writing 1 to bit 0 at 0x08 clears the counter and prescaler on that write's clock edge. It is an update event, and `trig_out` is 1 for exactly the following cycle.
- R5: With select 000, a one-cycle `slv_rst` clears the counter on the next edge. `trig_out` goes high one cycle later than the counter clear, for one cycle.
- R6: With select 001, `trig_out` equals the counter enable (bit 0 at 0x00 OR `gate_in`) registered by one clock.
- R7: With select 010, `trig_out` is a one-cycle pulse in the cycle after each update event, at the same time the counter shows 0.
- R8: With select 011, `trig_out` pulses for one cycle after each counting step whose new count equals the compare value. This happens even when the channel 1 flag is already 1.
- R9: The channel 1 flag at 0x10 bit 0 is set by every compare match, including a match in the same cycle as a clearing write. Writing 0 clears it. Clearing it never changes the compare pulse.
- R10: `upd_dma_req` is a one-cycle strobe after each update event while 0x0C bit 8 is 1. It stays 0 while that bit is 0.
- R11: Select values 100 through 111 hold `trig_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address (read and write) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| slv_rst | input | 1 | Counter restart from slave logic |
| gate_in | input | 1 | Gated-mode enable level |
| trig_out | output | 1 | Master synchronization trigger |
| upd_dma_req | output | 1 | Update DMA request strobe |

## Verification
The hardest case to reach from the ports is a compare match that lands while the channel 1 flag is already set, or in the same cycle as a write that clears the flag. The pulse must still appear, and the flag must end up set. The stimulus uses a small prescaler and auto-reload so that matches repeat every few cycles. It lets the flag saturate, then issues clearing writes at several phases relative to the match cycle. Two further cases are also driven: a slave restart arriving next to an update-generate write, and enable changes that come from the gate input while the software enable is off.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_t;

    localparam logic [2:0] MM_RESET  = 3'd0;
    localparam logic [2:0] MM_ENABLE = 3'd1;
    localparam logic [2:0] MM_UPDATE = 3'd2;
    localparam logic [2:0] MM_CMP    = 3'd3;

    localparam int ADDR_W      = 6;
    localparam int DEN_UPD_BIT = 8;

    localparam logic [ADDR_W-1:0] ADR_CTL  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_MODE = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_EVT  = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_DEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] ADR_STS  = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 6'h14;
    localparam logic [ADDR_W-1:0] ADR_PSC  = 6'h18;
    localparam logic [ADDR_W-1:0] ADR_ARR  = 6'h1C;
    localparam logic [ADDR_W-1:0] ADR_CMP  = 6'h20;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag_set,
    output logic              en_sw,
    output logic [2:0]        mst_sel,
    output logic              dma_en,
    output logic [CNT_W-1:0]  psc_val,
    output logic [CNT_W-1:0]  arr_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              ch1_flag,
    output logic              ug_evt
);

    logic wr_ctl, wr_mode, wr_den, wr_sts, wr_psc, wr_arr, wr_cmp;

    always_comb begin
        wr_ctl  = bus_wr && (bus_addr == ADR_CTL);
        wr_mode = bus_wr && (bus_addr == ADR_MODE);
        wr_den  = bus_wr && (bus_addr == ADR_DEN);
        wr_sts  = bus_wr && (bus_addr == ADR_STS);
        wr_psc  = bus_wr && (bus_addr == ADR_PSC);
        wr_arr  = bus_wr && (bus_addr == ADR_ARR);
        wr_cmp  = bus_wr && (bus_addr == ADR_CMP);
        ug_evt  = bus_wr && (bus_addr == ADR_EVT) && bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_sw   <= 1'b0;
            mst_sel <= MM_RESET;
            dma_en  <= 1'b0;
            psc_val <= '0;
            arr_val <= '0;
            cmp_val <= '0;
        end else begin
            if (wr_ctl)  en_sw   <= bus_wdata[0];
            if (wr_mode) mst_sel <= bus_wdata[2:0];
            if (wr_den)  dma_en  <= bus_wdata[DEN_UPD_BIT];
            if (wr_psc)  psc_val <= bus_wdata;
            if (wr_arr)  arr_val <= bus_wdata;
            if (wr_cmp)  cmp_val <= bus_wdata;
        end
    end

    // Match has priority over a clearing write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch1_flag <= 1'b0;
        end else if (flag_set) begin
            ch1_flag <= 1'b1;
        end else if (wr_sts && !bus_wdata[0]) begin
            ch1_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTL:  bus_rdata[0]           = en_sw;
            ADR_MODE: bus_rdata[2:0]         = mst_sel;
            ADR_DEN:  bus_rdata[DEN_UPD_BIT] = dma_en;
            ADR_STS:  bus_rdata[0]           = ch1_flag;
            ADR_CNT:  bus_rdata              = cnt_val;
            ADR_PSC:  bus_rdata              = psc_val;
            ADR_ARR:  bus_rdata              = arr_val;
            ADR_CMP:  bus_rdata              = cmp_val;
            default:  bus_rdata              = '0;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_sw,
    input  logic             gate_in,
    input  logic             ug_evt,
    input  logic             slv_rst,
    input  logic [CNT_W-1:0] psc_val,
    input  logic [CNT_W-1:0] arr_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             cnt_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             upd_evt,
    output logic             match_evt
);

    run_st_t          state, state_nxt;
    logic [CNT_W-1:0] psc_cnt;
    logic [CNT_W-1:0] cnt_step;
    logic             tick, wrap, restart;

    assign cnt_en = en_sw | gate_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT:  if (cnt_en)  state_nxt = ST_COUNT;
            ST_COUNT: if (!cnt_en) state_nxt = ST_HALT;
            default:  state_nxt = ST_HALT;
        endcase
    end

    always_comb begin
        restart   = ug_evt | slv_rst;
        tick      = (state == ST_COUNT) && (psc_cnt == psc_val);
        wrap      = tick && (cnt_q == arr_val);
        cnt_step  = wrap ? '0 : cnt_q + 1'b1;
        upd_evt   = ug_evt | (!slv_rst && wrap);
        match_evt = !restart && tick && (cnt_step == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            psc_cnt <= '0;
        end else if (restart) begin
            cnt_q   <= '0;
            psc_cnt <= '0;
        end else if (state == ST_COUNT) begin
            if (tick) begin
                psc_cnt <= '0;
                cnt_q   <= cnt_step;
            end else begin
                psc_cnt <= psc_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_trgo.sv
module tmr_trgo
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mst_sel,
    input  logic       ug_evt,
    input  logic       slv_rst,
    input  logic       cnt_en,
    input  logic       upd_evt,
    input  logic       match_evt,
    input  logic       dma_en,
    output logic       trig_out,
    output logic       upd_dma_req
);

    logic slv_rst_d;
    logic trig_nxt;

    always_comb begin
        trig_nxt = 1'b0;
        unique case (mst_sel)
            MM_RESET:  trig_nxt = ug_evt | slv_rst_d;
            MM_ENABLE: trig_nxt = cnt_en;
            MM_UPDATE: trig_nxt = upd_evt;
            MM_CMP:    trig_nxt = match_evt;
            default:   trig_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_rst_d   <= 1'b0;
            trig_out    <= 1'b0;
            upd_dma_req <= 1'b0;
        end else begin
            slv_rst_d   <= slv_rst;
            trig_out    <= trig_nxt;
            upd_dma_req <= upd_evt & dma_en;
        end
    end

endmodule

// File: rtl/tmr_trig_master.sv
module tmr_trig_master
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              slv_rst,
    input  logic              gate_in,
    output logic              trig_out,
    output logic              upd_dma_req
);

    logic             en_sw, dma_en, ch1_flag, ug_evt;
    logic [2:0]       mst_sel;
    logic [CNT_W-1:0] psc_val, arr_val, cmp_val, cnt_q;
    logic             cnt_en, upd_evt, match_evt;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_q),
        .flag_set  (match_evt),
        .en_sw     (en_sw),
        .mst_sel   (mst_sel),
        .dma_en    (dma_en),
        .psc_val   (psc_val),
        .arr_val   (arr_val),
        .cmp_val   (cmp_val),
        .ch1_flag  (ch1_flag),
        .ug_evt    (ug_evt)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_sw     (en_sw),
        .gate_in   (gate_in),
        .ug_evt    (ug_evt),
        .slv_rst   (slv_rst),
        .psc_val   (psc_val),
        .arr_val   (arr_val),
        .cmp_val   (cmp_val),
        .cnt_en    (cnt_en),
        .cnt_q     (cnt_q),
        .upd_evt   (upd_evt),
        .match_evt (match_evt)
    );

    tmr_trgo u_trgo (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_sel     (mst_sel),
        .ug_evt      (ug_evt),
        .slv_rst     (slv_rst),
        .cnt_en      (cnt_en),
        .upd_evt     (upd_evt),
        .match_evt   (match_evt),
        .dma_en      (dma_en),
        .trig_out    (trig_out),
        .upd_dma_req (upd_dma_req)
    );

endmodule

// File: rtl/tmr_trig_master_chk.sv
module tmr_trig_master_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel,
    input logic             en_sw,
    input logic             gate_in,
    input logic             slv_rst,
    input logic             ug_evt,
    input logic             upd_evt,
    input logic             match_evt,
    input logic             dma_en,
    input logic             ch1_flag,
    input logic [CNT_W-1:0] cnt_q,
    input logic             trig_out,
    input logic             upd_dma_req
);

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> (cnt_q == '0));

    assert_ug_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_evt && sel == 3'd0) |=> trig_out);

    assert_slv_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0 && $past(slv_rst)) |=> trig_out);

    assert_enable_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd1) |=> (trig_out == $past(en_sw | gate_in)));

    assert_update_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd2 && upd_evt) |=> trig_out);

    assert_match_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd3 && match_evt) |=> trig_out);

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> ch1_flag);

    assert_dma_on_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && dma_en) |=> upd_dma_req);

    assert_dma_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !upd_dma_req);

    assert_unused_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= 3'd4) |=> !trig_out);

endmodule

bind tmr_trig_master tmr_trig_master_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (mst_sel),
    .en_sw       (en_sw),
    .gate_in     (gate_in),
    .slv_rst     (slv_rst),
    .ug_evt      (ug_evt),
    .upd_evt     (upd_evt),
    .match_evt   (match_evt),
    .dma_en      (dma_en),
    .ch1_flag    (ch1_flag),
    .cnt_q       (cnt_q),
    .trig_out    (trig_out),
    .upd_dma_req (upd_dma_req)
);

// File: tb/tmr_trig_master_tb.sv
module tmr_trig_master_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h14;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        slv_rst = 1'b0;
    logic        gate_in = 1'b0;
    logic        trig_out;
    logic        upd_dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_trig_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slv_rst(slv_rst),
        .gate_in(gate_in), .trig_out(trig_out), .upd_dma_req(upd_dma_req)
    );

    // Behavioural reference state
    bit          m_en, m_dma, m_flag, m_run, m_slvd, m_trig, m_dreq;
    int          m_sel;
    int          m_psc, m_arr, m_cmp, m_cnt, m_pc;
    string       trig_tag;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            'h00: return int'(m_en);
            'h04: return m_sel;
            'h0C: return int'(m_dma) << 8;
            'h10: return int'(m_flag);
            'h14: return m_cnt;
            'h18: return m_psc;
            'h1C: return m_arr;
            'h20: return m_cmp;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        bit ug, en, tick, upd, match;
        int a, d, nxt;
        a = int'(bus_addr);
        d = int'(bus_wdata);
        ug = bus_wr && a == 'h08 && d[0];
        en = m_en | gate_in;
        tick = m_run && (m_pc == m_psc);
        upd = 1'b0;
        match = 1'b0;
        if (ug) begin
            m_cnt = 0; m_pc = 0; upd = 1'b1;
        end else if (slv_rst) begin
            m_cnt = 0; m_pc = 0;
        end else if (m_run) begin
            if (tick) begin
                m_pc = 0;
                if (m_cnt == m_arr) begin nxt = 0; upd = 1'b1; end
                else nxt = (m_cnt + 1) & 'hFFFF;
                m_cnt = nxt;
                match = (nxt == m_cmp);
            end else m_pc = m_pc + 1;
        end
        case (m_sel)
            0: begin m_trig = ug || m_slvd; trig_tag = m_slvd ? "R5" : "R4"; end
            1: begin m_trig = en; trig_tag = "R6"; end
            2: begin m_trig = upd; trig_tag = "R7"; end
            3: begin m_trig = match; trig_tag = "R8"; end
            default: begin m_trig = 1'b0; trig_tag = "R11"; end
        endcase
        m_dreq = upd && m_dma;
        if (match) m_flag = 1'b1;
        else if (bus_wr && a == 'h10 && !d[0]) m_flag = 1'b0;
        if (bus_wr) begin
            case (a)
                'h00: m_en = d[0];
                'h04: m_sel = d & 7;
                'h0C: m_dma = d[8];
                'h18: m_psc = d;
                'h1C: m_arr = d;
                'h20: m_cmp = d;
                default: ;
            endcase
        end
        m_run = en;
        m_slvd = slv_rst;
    endtask

    // Per-clock comparison against the reference
    always begin
        @(posedge clk);
        if (rst_n && !done) begin
            model_step();
            #(CLK_P/4);
            check(trig_tag, int'(trig_out), int'(m_trig));
            check("R10", int'(upd_dma_req), int'(m_dreq));
            case (int'(bus_addr))
                'h14: check("R3", int'(bus_rdata), model_read('h14));
                'h10: check("R9", int'(bus_rdata), model_read('h10));
                default: check("R2", int'(bus_rdata), model_read(int'(bus_addr)));
            endcase
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h14;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_slv();
        @(negedge clk); slv_rst = 1'b1;
        @(negedge clk); slv_rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 60000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_dma = 0; m_flag = 0; m_run = 0; m_slvd = 0; m_trig = 0; m_dreq = 0;
        m_sel = 0; m_psc = 0; m_arr = 0; m_cmp = 0; m_cnt = 0; m_pc = 0;
        trig_tag = "R4";
        idle(3);
        // R1: reset state
        check("R1", int'(trig_out), 0);
        check("R1", int'(upd_dma_req), 0);
        for (int a = 0; a <= 'h20; a += 4) begin
            bus_addr = 6'(a);
            #1;
            check("R1", int'(bus_rdata), 0);
        end
        bus_addr = 6'h14;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2: field masking
        wr(6'h04, 16'hFFF8);
        wr(6'h0C, 16'hFEFF);
        wr(6'h00, 16'hFFFE);
        wr(6'h08, 16'hFFFE);
        @(negedge clk); bus_addr = 6'h04; #1; check("R2", int'(bus_rdata), 0);
        wr(6'h04, 16'hFFFF);
        @(negedge clk); bus_addr = 6'h04; #1; check("R2", int'(bus_rdata), 7);
        bus_addr = 6'h08; #1; check("R2", int'(bus_rdata), 0);
        bus_addr = 6'h14;

        // R3, R7, R10: update sourced trigger with DMA enabled
        wr(6'h18, 16'd2);
        wr(6'h1C, 16'd4);
        wr(6'h0C, 16'h0100);
        wr(6'h04, 16'd2);
        wr(6'h00, 16'd1);
        idle(50);
        wr(6'h18, 16'd0);
        wr(6'h1C, 16'd0);
        idle(10);
        wr(6'h1C, 16'd3);
        idle(20);

        // R4, R5: restart sourced trigger
        wr(6'h04, 16'd0);
        idle(5);
        wr(6'h08, 16'd1);
        idle(4);
        pulse_slv();
        idle(4);
        @(negedge clk); slv_rst = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 16'd1;
        @(negedge clk); slv_rst = 1'b0; bus_wr = 1'b0; bus_addr = 6'h14;
        idle(3);
        pulse_slv();
        pulse_slv();
        idle(6);

        // R6: enable sourced trigger, gate only
        wr(6'h04, 16'd1);
        wr(6'h00, 16'd0);
        idle(4);
        @(negedge clk); gate_in = 1'b1;
        idle(7);
        @(negedge clk); gate_in = 1'b0;
        idle(3);
        wr(6'h00, 16'd1);
        idle(3);
        @(negedge clk); gate_in = 1'b1;
        idle(2);
        wr(6'h00, 16'd0);
        idle(3);
        @(negedge clk); gate_in = 1'b0;
        idle(3);

        // R8, R9: compare pulses, flag saturation and clears at several phases
        wr(6'h18, 16'd1);
        wr(6'h1C, 16'd5);
        wr(6'h20, 16'd3);
        wr(6'h04, 16'd3);
        wr(6'h00, 16'd1);
        @(negedge clk); bus_addr = 6'h10;
        idle(40);
        for (int ph = 0; ph < 12; ph++) begin
            @(negedge clk); bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 16'(ph & 1 ? 1 : 0);
            @(negedge clk); bus_wr = 1'b0; bus_addr = 6'h10;
            idle(ph % 5);
        end
        wr(6'h20, 16'd0);
        idle(30);
        wr(6'h18, 16'd0);
        wr(6'h20, 16'd2);
        @(negedge clk); bus_addr = 6'h10;
        for (int ph = 0; ph < 8; ph++) begin
            @(negedge clk); bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 16'd0;
            @(negedge clk); bus_wr = 1'b0;
        end
        idle(10);

        // R10: DMA disabled, updates continue
        wr(6'h0C, 16'h0000);
        wr(6'h04, 16'd2);
        idle(30);
        wr(6'h08, 16'd1);
        idle(5);
        wr(6'h0C, 16'h0100);
        idle(20);

        // R11: unused selects
        for (int s = 4; s < 8; s++) begin
            wr(6'h04, 16'(s));
            wr(6'h08, 16'd1);
            pulse_slv();
            @(negedge clk); gate_in = 1'b1;
            idle(12);
            @(negedge clk); gate_in = 1'b0;
        end
        wr(6'h00, 16'd0);
        idle(5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule